// File: doc/BRIEF.md
# SPI-3 Receive Link Interface

This block is the link-layer end of a 32-bit SPI-3 receive bus. A PHY device pushes packet data across the bus, together with in-band port addresses and per-word sideband flags. The block turns that stream into write operations for a bank of per-port virtual FIFOs. It keeps track of the port most recently announced in-band. It also checks bus parity with a selectable sense. Each accepted word is packed with its flags into one 40-bit FIFO word, and a write tag is issued alongside it. The tag holds the port number in its low bits and this interface's index in the two bits above them.

Flow control runs the other way. Each virtual FIFO supplies a flag that says its fill has reached the threshold. The block drives the bus read-enable (active low) from the flag of the port it is writing, so the PHY pauses once that FIFO nears full. The threshold is intended to be three-quarters full plus one. A parity error sets a sticky flag, which stays set until a clear strobe acknowledges it. Several instances, one per SPI-3 link, can feed one shared FIFO bank because their tags never collide.

Top module: `spi3_rx_link`

## Requirements
- R1: A bus cycle is a data cycle only when `rx_val` is 1 in that cycle and `rx_enb_n` was 0 in the previous cycle. Each data cycle, and no other cycle, produces exactly one write (`wr_en`=1) on the clock edge that ends it.
- R2: A cycle with `rx_val`=0 and `rx_sx`=1, where `rx_enb_n` was 0 in the previous cycle, is an address cycle. The low bits of `rx_dat` (the port-number width) become the current port, and no write results. An address indication arriving while the bus is paused is ignored. A cycle with both `rx_val` and `rx_sx` at 1 is treated as data and leaves the port unchanged.
- R3: The written word holds the received data in bits [31:0], start of packet in bit 32, end of packet in bit 33, the byte-valid nibble in bits [37:34] and the error flag in bit 38. Bit 39 is always 0.
- R4: On an end-of-packet word, the byte-valid nibble follows `rx_mod`: 00 gives 1111, 01 gives 1110, 10 gives 1100 and 11 gives 1000. On every other word it is 1111.
- R5: `wr_tag` carries the current port in bits [PW-1:0], where PW = log2(PORTS). It carries `IF_INDEX` in bits [PW+1:PW], and all higher bits are 0. With the default parameters (4 ports, index 2) the tag is 8 + port.
- R6: `rx_enb_n` is a register. It takes the threshold flag of the port that the next data words will go to: the newly addressed port in an address cycle, otherwise the current port. Flags of other ports have no effect on it.
- R7: With `par_odd`=1, a data cycle is a parity error when `rx_dat` together with `rx_par` has an even number of ones. With `par_odd`=0, it is an error when that number is odd. Parity is not checked outside data cycles.
- R8: `par_err` rises on the edge after a parity error and stays set until a cycle with `par_clr`=1. A clear takes effect on that cycle's edge. When an error and a clear fall in the same cycle, the error wins.
- R9: During and right after reset, `rx_enb_n`=1, `wr_en`=0 and `par_err`=0, and the current port is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_val | input | 1 | Receive data valid |
| rx_dat | input | 32 | Receive data, or port address in an address cycle |
| rx_sx | input | 1 | Start-of-transfer (address) indication |
| rx_sop | input | 1 | Start of packet |
| rx_eop | input | 1 | End of packet |
| rx_err | input | 1 | Packet error |
| rx_mod | input | 2 | Count of unused bytes in the last word |
| rx_par | input | 1 | Bus parity bit |
| rx_enb_n | output | 1 | Read enable to the PHY, active low |
| par_odd | input | 1 | Parity sense: 1 odd, 0 even |
| fifo_thr | input | PORTS | Per-port FIFO at-threshold flags |
| par_clr | input | 1 | Clears the sticky parity error |
| wr_en | output | 1 | FIFO write enable |
| wr_word | output | 40 | FIFO write word |
| wr_tag | output | 8 | Interface-plus-port write tag |
| par_err | output | 1 | Sticky parity error |

## Verification
The bound checker watches several properties on every cycle. A write must follow a valid-and-enabled bus cycle, and it must copy that cycle's data. Bit 39 must stay 0, and a non-final word must carry all four byte-valid bits. The tag must always hold the interface index above the port field, and the sticky error must not fall without a clear. Other behaviour can only be shown through the bench's scenarios: the exact byte-valid values for each modulo, whether a tag names the port announced earlier, and that an address arriving during a pause is dropped. The same holds for read-enable tracking only the selected port's threshold, the even-sense parity check, and an error beating a clear in the same cycle.

// File: rtl/spi3_rx_link.sv
module spi3_rx_link #(
  parameter int PORTS    = 4,
  parameter int IF_INDEX = 2,
  parameter int PCW      = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_val,
  input  logic [31:0]      rx_dat,
  input  logic             rx_sx,
  input  logic             rx_sop,
  input  logic             rx_eop,
  input  logic             rx_err,
  input  logic [1:0]       rx_mod,
  input  logic             rx_par,
  output logic             rx_enb_n,
  input  logic             par_odd,
  input  logic [PORTS-1:0] fifo_thr,
  input  logic             par_clr,
  output logic             wr_en,
  output logic [39:0]      wr_word,
  output logic [7:0]       wr_tag,
  output logic             par_err
);
  localparam int PW = (PORTS > 1) ? $clog2(PORTS) : 0;
  localparam logic [7:0] IF_FIELD = 8'(IF_INDEX % 4) << PW;

  logic           enb_prev;
  logic [PCW-1:0] cur_port, nxt_port, addr_in;
  logic           data_cyc, addr_cyc, par_bad;
  logic [3:0]     bvalid;

  assign data_cyc = rx_val & ~enb_prev;
  assign addr_cyc = ~rx_val & rx_sx & ~enb_prev;
  assign addr_in  = (PORTS > 1) ? rx_dat[PCW-1:0] : '0;
  assign nxt_port = addr_cyc ? addr_in : cur_port;
  assign par_bad  = data_cyc & ((^rx_dat ^ rx_par) != par_odd);
  assign bvalid   = rx_eop ? (4'hf << rx_mod) : 4'hf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_enb_n <= 1'b1;
      enb_prev <= 1'b1;
      cur_port <= '0;
      wr_en    <= 1'b0;
      wr_word  <= '0;
      wr_tag   <= '0;
      par_err  <= 1'b0;
    end else begin
      rx_enb_n <= fifo_thr[nxt_port];
      enb_prev <= rx_enb_n;
      cur_port <= nxt_port;
      wr_en    <= data_cyc;
      if (data_cyc) begin
        wr_word <= {1'b0, rx_err, bvalid, rx_eop, rx_sop, rx_dat};
        wr_tag  <= IF_FIELD | 8'(cur_port);
      end
      par_err  <= par_bad | (par_err & ~par_clr);
    end
  end
endmodule

// File: rtl/spi3_rx_link_chk.sv
module spi3_rx_link_chk #(
  parameter int PORTS    = 4,
  parameter int IF_INDEX = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_val,
  input logic [31:0] rx_dat,
  input logic        rx_enb_n,
  input logic        par_clr,
  input logic        wr_en,
  input logic [39:0] wr_word,
  input logic [7:0]  wr_tag,
  input logic        par_err
);
  localparam int PW = (PORTS > 1) ? $clog2(PORTS) : 0;

  // R1
  write_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(rx_val) && !$past(rx_enb_n, 2)));

  // R1
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_val |=> !wr_en);

  // R3
  data_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_word[31:0] == $past(rx_dat));

  // R3
  top_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !wr_word[39]);

  // R4
  full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_word[33]) |-> wr_word[37:34] == 4'hf);

  // R5
  tag_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_tag >> PW) == 8'(IF_INDEX % 4));

  // R8
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !par_clr) |=> par_err);
endmodule

bind spi3_rx_link spi3_rx_link_chk #(.PORTS(PORTS), .IF_INDEX(IF_INDEX)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_val(rx_val), .rx_dat(rx_dat),
  .rx_enb_n(rx_enb_n), .par_clr(par_clr), .wr_en(wr_en),
  .wr_word(wr_word), .wr_tag(wr_tag), .par_err(par_err));

// File: tb/tb_spi3_rx_link.sv
module tb_spi3_rx_link;
  localparam int PORTS = 4;
  localparam int IFX   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_val = 1'b0, rx_sx = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
  logic        rx_err = 1'b0, rx_par = 1'b0, par_odd = 1'b1, par_clr = 1'b0;
  logic [31:0] rx_dat = '0;
  logic [1:0]  rx_mod = '0;
  logic [3:0]  fifo_thr = '0;
  logic        rx_enb_n, wr_en, par_err;
  logic [39:0] wr_word;
  logic [7:0]  wr_tag;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi3_rx_link #(.PORTS(PORTS), .IF_INDEX(IFX)) dut (
    .clk(clk), .rst_n(rst_n), .rx_val(rx_val), .rx_dat(rx_dat), .rx_sx(rx_sx),
    .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_err(rx_err), .rx_mod(rx_mod),
    .rx_par(rx_par), .rx_enb_n(rx_enb_n), .par_odd(par_odd),
    .fifo_thr(fifo_thr), .par_clr(par_clr), .wr_en(wr_en),
    .wr_word(wr_word), .wr_tag(wr_tag), .par_err(par_err));

  // {port[2:0], badpar, err, mod[1:0], eop, sop, dat[31:0]}
  localparam logic [40:0] VEC [8] = '{
    {3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 32'h1234_5678},
    {3'd1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 32'hDEAD_BEEF},
    {3'd2, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 32'h0000_0001},
    {3'd3, 1'b0, 1'b1, 2'd2, 1'b1, 1'b1, 32'hFFFF_FFFF},
    {3'd0, 1'b0, 1'b0, 2'd3, 1'b1, 1'b0, 32'hA5A5_5A5A},
    {3'd3, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 32'h8000_0000},
    {3'd2, 1'b0, 1'b0, 2'd2, 1'b0, 1'b1, 32'h0F0F_F0F0},
    {3'd1, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic par_of(input logic [31:0] d, input logic odd, input logic bad);
    return (^d) ^ odd ^ bad;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    rx_val = 1'b0; rx_sx = 1'b0; par_clr = 1'b0;
  endtask

  task automatic drive_addr(input logic [7:0] p, input logic clr);
    @(negedge clk);
    rx_val = 1'b0; rx_sx = 1'b1; rx_dat = {24'h0, p}; par_clr = clr;
    tick();
  endtask

  task automatic drive_data(input logic [31:0] d, input logic sop, input logic eop,
                            input logic [1:0] m, input logic e, input logic bad,
                            input logic sx, input logic clr);
    @(negedge clk);
    rx_val = 1'b1; rx_sx = sx; rx_dat = d; rx_sop = sop; rx_eop = eop;
    rx_mod = m; rx_err = e; rx_par = par_of(d, par_odd, bad); par_clr = clr;
    tick();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] bv;
    logic [7:0] last_tag;
    repeat (3) tick();
    check("R9 enb at reset", rx_enb_n, 1);
    check("R9 wr_en at reset", wr_en, 0);
    check("R9 par_err at reset", par_err, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) tick();
    check("R6 enb open after reset", rx_enb_n, 0);

    for (int i = 0; i < 8; i++) begin
      drive_addr({5'd0, VEC[i][40:38]}, 1'b1);
      drive_data(VEC[i][31:0], VEC[i][32], VEC[i][33], VEC[i][35:34],
                 VEC[i][36], VEC[i][37], 1'b0, 1'b0);
      bv = VEC[i][33] ? (4'hf << VEC[i][35:34]) : 4'hf;
      check("R1 write on data cycle", wr_en, 1);
      check("R3 R4 word layout", wr_word,
            {1'b0, VEC[i][36], bv, VEC[i][33], VEC[i][32], VEC[i][31:0]});
      check("R5 R2 tag", wr_tag, 8'((IFX << 2) | VEC[i][40:38]));
      check("R7 odd parity", par_err, VEC[i][37]);
      idle();
      tick();
      check("R1 no write after idle", wr_en, 0);
    end
    last_tag = 8'((IFX << 2) | 1);

    // pause: threshold on current port closes the bus
    @(negedge clk); fifo_thr = 4'hf;
    repeat (2) tick();
    drive_data(32'h5555_0000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R1 no write while paused", wr_en, 0);
    check("R6 enb high on threshold", rx_enb_n, 1);
    drive_addr(8'd3, 1'b0);
    idle(); fifo_thr = 4'h0;
    repeat (2) tick();
    check("R6 enb reopens", rx_enb_n, 0);
    drive_data(32'h0BAD_F00D, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R1 write after reopen", wr_en, 1);
    check("R2 paused address ignored", wr_tag, last_tag);

    // val and sx both high: data, port kept
    drive_data(32'h7777_7777, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R2 sx with val is data", wr_en, 1);
    check("R2 sx with val keeps port", wr_tag, last_tag);
    idle();

    // threshold of another port is ignored; new port's flag applies at once
    fifo_thr = 4'b1000;
    repeat (2) tick();
    check("R6 other port flag ignored", rx_enb_n, 0);
    drive_addr(8'd3, 1'b0);
    check("R6 newly addressed port flag", rx_enb_n, 1);
    idle(); fifo_thr = 4'h0;
    repeat (2) tick();

    // even parity sense, set wins over clear, clear
    par_odd = 1'b0;
    drive_data(32'h0000_0007, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R7 even good", par_err, 0);
    check("R5 tag port 3", wr_tag, 8'((IFX << 2) | 3));
    drive_data(32'h0000_0007, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R8 error wins over clear", par_err, 1);
    idle();
    tick();
    check("R8 sticky holds", par_err, 1);
    @(negedge clk); par_clr = 1'b1;
    tick();
    check("R8 clear", par_err, 0);
    idle();
    rx_par = 1'b1;
    rx_sx = 1'b1;
    tick();
    check("R7 no check outside data", par_err, 0);
    check("R2 address cycle no write", wr_en, 0);
    idle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule